// File: doc/BRIEF.md
# Wide Free-Running Counter with Self-Rearming Comparator

This block keeps a 64-bit count that advances by one on every clock while enabled, and a single 64-bit compare channel. Software talks to it through a flat 32-bit register bank. It can preset either half of the count and load either half of the compare value. It can also set a 32-bit step value and choose, through a control word, whether the counter runs and whether the comparator is armed. In periodic mode the comparator moves its own target forward by the step each time it fires, which gives an evenly spaced interrupt with no software help.

A match sets a sticky status flag. The interrupt output is that flag masked by an enable bit. Every write passes through a fixed two-stage delay before it takes effect. Each configuration register then reports that its value has landed by setting its own acknowledge bit, which software clears by writing one. Both counter halves always change on the same clock edge. Software can therefore read the count as high, low, high and retry when the two high reads differ.

Top module: `wide_tick_comparator`

## Requirements
- R1: After reset the count, compare value, step, control word, interrupt enable, status flag, both acknowledge registers and the `irq` output all read zero.
- R2: With control bit 0 (run) set, the count grows by exactly one per clock. With it clear, and no preset, the count holds its value.
- R3: A write to word 0 or word 1 replaces the low or high 32 bits of the count, and the other half is kept. A carry out of the low half reaches the high half on the same edge that wraps the low half.
- R4: A write that takes effect sets its acknowledge bit. In the acknowledge register at word 6, bit 0 is for the compare low word (word 2), bit 1 for the compare high word (word 3), bit 2 for the step (word 4) and bit 16 for control (word 5). In the acknowledge register at word 7, bit 0 is for count low and bit 1 for count high. A write to an unmapped word (10 to 15) changes nothing.
- R5: Writing a mask to word 6 or word 7 clears exactly the acknowledge bits that are 1 in the mask and leaves the others unchanged.
- R6: While control bit 1 (compare enable) is set, the clock edge at which the count equals the compare value sets status bit 0 (word 9). The bit stays set until software writes 1 to it.
- R7: The `irq` output is high exactly while status bit 0 and enable bit 0 (word 8) are both set.
- R8: With control bit 2 (auto step) set, each match adds the zero-extended step to the 64-bit compare value on the match edge, including the carry into the high half.
- R9: With compare enable clear, the count passing the compare value leaves the status bit clear.
- R10: A register write takes effect on the second clock edge after the edge that accepts it. One edge after acceptance, the old value still reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, accepted on a rising clock edge |
| wr_addr | input | 4 | Word index of the register written |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Word index of the register read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq | output | 1 | Compare interrupt (status AND enable) |

## Verification
The assertions assume that at most one write is accepted per clock and that write data is stable while `wr_en` is high. They also assume that a preset and a compare reload never come from the same write, since the register bank decodes one word per write. The bench drives every write from a single task that raises `wr_en` for exactly one edge between falling edges. Each match scenario stops the counter and presets both count and compare value before it re-arms. This keeps the edge on which a match, an auto step or a carry happens known in advance.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

   localparam int REG_IDX_W   = 4;

   localparam logic [REG_IDX_W-1:0] IDX_CNT_LO   = 4'd0;
   localparam logic [REG_IDX_W-1:0] IDX_CNT_HI   = 4'd1;
   localparam logic [REG_IDX_W-1:0] IDX_CMP_LO   = 4'd2;
   localparam logic [REG_IDX_W-1:0] IDX_CMP_HI   = 4'd3;
   localparam logic [REG_IDX_W-1:0] IDX_STEP     = 4'd4;
   localparam logic [REG_IDX_W-1:0] IDX_CTRL     = 4'd5;
   localparam logic [REG_IDX_W-1:0] IDX_WACK     = 4'd6;
   localparam logic [REG_IDX_W-1:0] IDX_CNT_WACK = 4'd7;
   localparam logic [REG_IDX_W-1:0] IDX_IRQ_EN   = 4'd8;
   localparam logic [REG_IDX_W-1:0] IDX_IRQ_STAT = 4'd9;

   localparam int CTRL_W      = 3;
   localparam int CTRL_RUN    = 0;
   localparam int CTRL_CMP_EN = 1;
   localparam int CTRL_AUTO   = 2;

   localparam int ACK_CMP_LO  = 0;
   localparam int ACK_CMP_HI  = 1;
   localparam int ACK_STEP    = 2;
   localparam int ACK_CTRL    = 16;

   localparam int CACK_LO     = 0;
   localparam int CACK_HI     = 1;

endpackage

// File: rtl/wtc_wr_pipe.sv
module wtc_wr_pipe #(
   parameter int W   = 37,
   parameter int LAT = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_vld,
   input  logic [W-1:0] in_pay,
   output logic         out_vld,
   output logic [W-1:0] out_pay
);

   generate
      if (LAT < 0) begin : g_bad_lat
         $error("wtc_wr_pipe: LAT must not be negative");
      end

      if (LAT == 0) begin : g_direct
         assign out_vld = in_vld;
         assign out_pay = in_pay;
      end else begin : g_stages
         logic [LAT-1:0] vld_q;
         logic [W-1:0]   pay_q [LAT];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q <= '0;
            end else begin
               vld_q[0] <= in_vld;
               for (int s = 1; s < LAT; s++) begin
                  vld_q[s] <= vld_q[s-1];
               end
            end
         end

         always_ff @(posedge clk) begin
            pay_q[0] <= in_pay;
            for (int s = 1; s < LAT; s++) begin
               pay_q[s] <= pay_q[s-1];
            end
         end

         assign out_vld = vld_q[LAT-1];
         assign out_pay = pay_q[LAT-1];
      end
   endgenerate

endmodule

// File: rtl/wtc_counter.sv
module wtc_counter #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              set_lo,
   input  logic              set_hi,
   input  logic [DATA_W-1:0] set_val,
   output logic [CNT_W-1:0]  cnt
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;

   always_comb begin
      cnt_d = cnt_q;
      if (set_lo || set_hi) begin
         if (set_lo) cnt_d[DATA_W-1:0]     = set_val;
         if (set_hi) cnt_d[CNT_W-1:DATA_W] = set_val;
      end else if (run) begin
         cnt_d = cnt_q + CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign cnt = cnt_q;

endmodule

// File: rtl/wtc_comparator.sv
module wtc_comparator #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 64,
   parameter int STEP_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              enable,
   input  logic              auto_step,
   input  logic              set_lo,
   input  logic              set_hi,
   input  logic              set_step,
   input  logic [DATA_W-1:0] set_val,
   input  logic [STEP_W-1:0] step_val,
   input  logic              flag_clr,
   output logic [CNT_W-1:0]  cmp,
   output logic [STEP_W-1:0] step,
   output logic              flag
);

   logic [CNT_W-1:0]  cmp_q;
   logic [STEP_W-1:0] step_q;
   logic              flag_q;
   logic              hit;

   assign hit = enable && (cnt == cmp_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= '0;
      end else if (set_lo || set_hi) begin
         if (set_lo) cmp_q[DATA_W-1:0]     <= set_val;
         if (set_hi) cmp_q[CNT_W-1:DATA_W] <= set_val;
      end else if (hit && auto_step) begin
         cmp_q <= cmp_q + CNT_W'(step_q);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        step_q <= '0;
      else if (set_step) step_q <= step_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (hit)      flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
   end

   assign cmp  = cmp_q;
   assign step = step_q;
   assign flag = flag_q;

endmodule

// File: rtl/wtc_ack_bank.sv
module wtc_ack_bank #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_bits,
   input  logic [W-1:0] clr_bits,
   output logic [W-1:0] q
);

   logic [W-1:0] q_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= '0;
      else        q_r <= (q_r & ~clr_bits) | set_bits;
   end

   assign q = q_r;

endmodule

// File: rtl/wide_tick_comparator.sv
module wide_tick_comparator
   import wtc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 64,
   parameter int STEP_W = 32,
   parameter int ADDR_W = 4,
   parameter int WR_LAT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq
);

   localparam int PAY_W = REG_IDX_W + DATA_W;

   generate
      if (CNT_W != 2 * DATA_W) begin : g_chk_cnt
         $error("CNT_W must be twice DATA_W");
      end
      if (STEP_W > DATA_W || STEP_W < 1) begin : g_chk_step
         $error("STEP_W must lie in 1..DATA_W");
      end
      if (DATA_W <= ACK_CTRL) begin : g_chk_data
         $error("DATA_W too narrow for the control acknowledge bit");
      end
      if (ADDR_W < REG_IDX_W) begin : g_chk_addr
         $error("ADDR_W must cover the register index");
      end
      if (WR_LAT < 1) begin : g_chk_lat
         $error("WR_LAT must be at least one");
      end
   endgenerate

   // write acceptance and delay
   logic                 wr_in_range;
   logic                 ap_vld;
   logic [PAY_W-1:0]     ap_pay;
   logic [REG_IDX_W-1:0] ap_idx;
   logic [DATA_W-1:0]    ap_data;

   assign wr_in_range = ((wr_addr >> REG_IDX_W) == '0);

   wtc_wr_pipe #(.W(PAY_W), .LAT(WR_LAT)) u_pipe (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (wr_en && wr_in_range),
      .in_pay  ({wr_addr[REG_IDX_W-1:0], wr_data}),
      .out_vld (ap_vld),
      .out_pay (ap_pay)
   );

   assign ap_idx  = ap_pay[PAY_W-1:DATA_W];
   assign ap_data = ap_pay[DATA_W-1:0];

   // decode of the write that takes effect this edge
   logic wr_cnt_lo, wr_cnt_hi, wr_cmp_lo, wr_cmp_hi, wr_step, wr_ctrl;
   logic wr_wack, wr_cwack, wr_irq_en, wr_irq_stat;

   assign wr_cnt_lo   = ap_vld && (ap_idx == IDX_CNT_LO);
   assign wr_cnt_hi   = ap_vld && (ap_idx == IDX_CNT_HI);
   assign wr_cmp_lo   = ap_vld && (ap_idx == IDX_CMP_LO);
   assign wr_cmp_hi   = ap_vld && (ap_idx == IDX_CMP_HI);
   assign wr_step     = ap_vld && (ap_idx == IDX_STEP);
   assign wr_ctrl     = ap_vld && (ap_idx == IDX_CTRL);
   assign wr_wack     = ap_vld && (ap_idx == IDX_WACK);
   assign wr_cwack    = ap_vld && (ap_idx == IDX_CNT_WACK);
   assign wr_irq_en   = ap_vld && (ap_idx == IDX_IRQ_EN);
   assign wr_irq_stat = ap_vld && (ap_idx == IDX_IRQ_STAT);

   // control and interrupt enable
   logic [CTRL_W-1:0] ctrl_q;
   logic              irq_en_q;
   logic              run_on, cmp_on, auto_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= ap_data[CTRL_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         irq_en_q <= 1'b0;
      else if (wr_irq_en) irq_en_q <= ap_data[0];
   end

   assign run_on  = ctrl_q[CTRL_RUN];
   assign cmp_on  = ctrl_q[CTRL_CMP_EN];
   assign auto_on = ctrl_q[CTRL_AUTO];

   // counter
   logic [CNT_W-1:0] cnt_q;

   wtc_counter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_counter (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_on),
      .set_lo  (wr_cnt_lo),
      .set_hi  (wr_cnt_hi),
      .set_val (ap_data),
      .cnt     (cnt_q)
   );

   // comparator
   logic [CNT_W-1:0]  cmp_q;
   logic [STEP_W-1:0] step_q;
   logic              stat_q;
   logic              stat_clr;

   assign stat_clr = wr_irq_stat && ap_data[0];

   wtc_comparator #(.DATA_W(DATA_W), .CNT_W(CNT_W), .STEP_W(STEP_W)) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt       (cnt_q),
      .enable    (cmp_on),
      .auto_step (auto_on),
      .set_lo    (wr_cmp_lo),
      .set_hi    (wr_cmp_hi),
      .set_step  (wr_step),
      .set_val   (ap_data),
      .step_val  (ap_data[STEP_W-1:0]),
      .flag_clr  (stat_clr),
      .cmp       (cmp_q),
      .step      (step_q),
      .flag      (stat_q)
   );

   // write acknowledge registers
   logic [DATA_W-1:0] gack_set, gack_clr, gack_q;
   logic [DATA_W-1:0] cack_set, cack_clr, cack_q;

   always_comb begin
      gack_set             = '0;
      gack_set[ACK_CMP_LO] = wr_cmp_lo;
      gack_set[ACK_CMP_HI] = wr_cmp_hi;
      gack_set[ACK_STEP]   = wr_step;
      gack_set[ACK_CTRL]   = wr_ctrl;
      gack_clr             = wr_wack ? ap_data : '0;

      cack_set             = '0;
      cack_set[CACK_LO]    = wr_cnt_lo;
      cack_set[CACK_HI]    = wr_cnt_hi;
      cack_clr             = wr_cwack ? ap_data : '0;
   end

   wtc_ack_bank #(.W(DATA_W)) u_gack (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_bits (gack_set),
      .clr_bits (gack_clr),
      .q        (gack_q)
   );

   wtc_ack_bank #(.W(DATA_W)) u_cack (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_bits (cack_set),
      .clr_bits (cack_clr),
      .q        (cack_q)
   );

   // read mux
   logic rd_in_range;

   assign rd_in_range = ((rd_addr >> REG_IDX_W) == '0);

   always_comb begin
      rd_data = '0;
      if (rd_in_range) begin
         case (rd_addr[REG_IDX_W-1:0])
            IDX_CNT_LO:   rd_data = cnt_q[DATA_W-1:0];
            IDX_CNT_HI:   rd_data = cnt_q[CNT_W-1:DATA_W];
            IDX_CMP_LO:   rd_data = cmp_q[DATA_W-1:0];
            IDX_CMP_HI:   rd_data = cmp_q[CNT_W-1:DATA_W];
            IDX_STEP:     rd_data = DATA_W'(step_q);
            IDX_CTRL:     rd_data = DATA_W'(ctrl_q);
            IDX_WACK:     rd_data = gack_q;
            IDX_CNT_WACK: rd_data = cack_q;
            IDX_IRQ_EN:   rd_data = DATA_W'(irq_en_q);
            IDX_IRQ_STAT: rd_data = DATA_W'(stat_q);
            default:      rd_data = '0;
         endcase
      end
   end

   assign irq = stat_q && irq_en_q;

endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 64,
   parameter int STEP_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  cmp,
   input logic [STEP_W-1:0] step,
   input logic              run,
   input logic              cmp_en,
   input logic              auto_on,
   input logic              cnt_wr,
   input logic              cmp_wr,
   input logic              stat,
   input logic              stat_clr,
   input logic [DATA_W-1:0] gack,
   input logic [DATA_W-1:0] cack,
   input logic              apply_vld
);

   assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !cnt_wr) |=> (cnt == $past(cnt) + CNT_W'(1)));

   assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_wr) |=> $stable(cnt));

   assert_ack_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|((gack & ~$past(gack)) | (cack & ~$past(cack)))) |-> $past(apply_vld));

   assert_flag_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat) |-> $past(cmp_en && (cnt == cmp)));

   assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat && !stat_clr) |=> stat);

   assert_rearm_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_en && auto_on && (cnt == cmp) && !cmp_wr)
         |=> (cmp == $past(cmp) + CNT_W'($past(step))));

   assert_off_no_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmp_en && !stat) |=> !stat);

endmodule

bind wide_tick_comparator wtc_checker #(
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W),
   .STEP_W (STEP_W)
) i_wtc_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .cnt       (cnt_q),
   .cmp       (cmp_q),
   .step      (step_q),
   .run       (run_on),
   .cmp_en    (cmp_on),
   .auto_on   (auto_on),
   .cnt_wr    (wr_cnt_lo || wr_cnt_hi),
   .cmp_wr    (wr_cmp_lo || wr_cmp_hi),
   .stat      (stat_q),
   .stat_clr  (stat_clr),
   .gack      (gack_q),
   .cack      (cack_q),
   .apply_vld (ap_vld)
);

// File: tb/test_wide_tick_comparator.sv
`timescale 1ns/1ps
module test_wide_tick_comparator;

   localparam logic [3:0] A_CNT_LO = 4'd0, A_CNT_HI = 4'd1, A_CMP_LO = 4'd2,
                          A_CMP_HI = 4'd3, A_STEP = 4'd4, A_CTRL = 4'd5,
                          A_WACK = 4'd6, A_CWACK = 4'd7, A_IEN = 4'd8,
                          A_STAT = 4'd9;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   wide_tick_comparator i_wide_tick_comparator (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic chk_reg(input string req, input logic [3:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(req, d, exp);
   endtask

   // one write accepted on the next rising edge; returns at the falling edge
   // right after the edge where it takes effect
   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset;
      chk_reg("R1 count low", A_CNT_LO, 0);
      chk_reg("R1 count high", A_CNT_HI, 0);
      chk_reg("R1 compare low", A_CMP_LO, 0);
      chk_reg("R1 control", A_CTRL, 0);
      chk_reg("R1 ack", A_WACK, 0);
      chk_reg("R1 count ack", A_CWACK, 0);
      chk_reg("R1 status", A_STAT, 0);
      chk("R1 irq", {31'd0, irq}, 0);
   endtask

   task automatic t_latency;
      wr_en = 1'b1; wr_addr = A_CMP_LO; wr_data = 32'h55;
      @(negedge clk);
      wr_en = 1'b0;
      @(negedge clk);
      chk_reg("R10 old compare one edge later", A_CMP_LO, 0);
      chk_reg("R10 no ack one edge later", A_WACK, 0);
      @(negedge clk);
      chk_reg("R10 compare applied", A_CMP_LO, 32'h55);
      chk_reg("R4 compare low ack bit0", A_WACK, 32'h1);
   endtask

   task automatic t_ack_clear;
      wr(A_STEP, 32'd7);
      chk_reg("R4 step ack bit2", A_WACK, 32'h5);
      wr(A_WACK, 32'h4);
      chk_reg("R5 clear bit2 only", A_WACK, 32'h1);
      wr(A_WACK, 32'h0);
      chk_reg("R5 zero mask keeps bits", A_WACK, 32'h1);
      wr(A_WACK, 32'h1);
      chk_reg("R5 clear bit0", A_WACK, 32'h0);
      wr(4'hC, 32'hFFFF_FFFF);
      chk_reg("R4 unmapped no ack", A_WACK, 32'h0);
      chk_reg("R4 unmapped no count ack", A_CWACK, 32'h0);
   endtask

   task automatic t_counter;
      wr(A_CNT_LO, 32'hFFFF_FFFE);
      wr(A_CNT_HI, 32'd7);
      chk_reg("R4 count ack bits", A_CWACK, 32'h3);
      chk_reg("R3 preset low", A_CNT_LO, 32'hFFFF_FFFE);
      chk_reg("R3 preset high", A_CNT_HI, 32'd7);
      wr(A_CNT_HI, 32'd2);
      chk_reg("R3 high write keeps low", A_CNT_LO, 32'hFFFF_FFFE);
      wr(A_CNT_HI, 32'd7);
      wr(A_CWACK, 32'h3);
      chk_reg("R5 count ack cleared", A_CWACK, 32'h0);
      wr(A_CTRL, 32'h1);
      chk_reg("R4 control ack bit16", A_WACK, 32'h0001_0000);
      chk_reg("R2 first cycle after start", A_CNT_LO, 32'hFFFF_FFFE);
      idle(2);
      chk_reg("R3 carry low", A_CNT_LO, 32'd0);
      chk_reg("R3 carry high same edge", A_CNT_HI, 32'd8);
      idle(10);
      chk_reg("R2 ten steps", A_CNT_LO, 32'd10);
      wr(A_CTRL, 32'h0);
      chk_reg("R2 stop value", A_CNT_LO, 32'd13);
      idle(5);
      chk_reg("R2 holds when stopped", A_CNT_LO, 32'd13);
   endtask

   task automatic t_match;
      wr(A_CNT_LO, 32'd100);
      wr(A_CNT_HI, 32'd0);
      wr(A_CMP_LO, 32'd110);
      wr(A_CMP_HI, 32'd0);
      wr(A_IEN, 32'd1);
      wr(A_CTRL, 32'h3);
      idle(10);
      chk_reg("R6 no flag before match", A_STAT, 0);
      chk("R7 irq low before match", {31'd0, irq}, 0);
      idle(1);
      chk_reg("R6 flag on match", A_STAT, 1);
      chk("R7 irq high", {31'd0, irq}, 1);
      idle(6);
      chk_reg("R6 flag held", A_STAT, 1);
      wr(A_IEN, 32'd0);
      chk("R7 irq masked", {31'd0, irq}, 0);
      wr(A_STAT, 32'd1);
      chk_reg("R6 flag cleared", A_STAT, 0);
      wr(A_CTRL, 32'h0);
   endtask

   task automatic t_disabled;
      wr(A_CNT_LO, 32'd200);
      wr(A_CMP_LO, 32'd205);
      wr(A_CTRL, 32'h1);
      idle(10);
      chk_reg("R9 no flag while disabled", A_STAT, 0);
      wr(A_CTRL, 32'h0);
   endtask

   task automatic t_auto;
      wr(A_CNT_LO, 32'd300);
      wr(A_CMP_LO, 32'd310);
      wr(A_STEP, 32'd25);
      wr(A_IEN, 32'd1);
      wr(A_CTRL, 32'h7);
      idle(11);
      chk_reg("R8 first match flag", A_STAT, 1);
      chk_reg("R8 compare stepped", A_CMP_LO, 32'd335);
      wr(A_STAT, 32'd1);
      chk_reg("R6 flag cleared between periods", A_STAT, 0);
      idle(21);
      chk_reg("R8 no flag before next period", A_STAT, 0);
      idle(1);
      chk_reg("R8 second period flag", A_STAT, 1);
      chk_reg("R8 compare stepped again", A_CMP_LO, 32'd360);
      chk("R7 irq periodic", {31'd0, irq}, 1);
      wr(A_CTRL, 32'h0);
      wr(A_STAT, 32'd1);
      wr(A_CNT_LO, 32'hFFFF_FFE0);
      wr(A_CNT_HI, 32'd2);
      wr(A_CMP_LO, 32'hFFFF_FFF0);
      wr(A_CMP_HI, 32'd2);
      wr(A_STEP, 32'h20);
      wr(A_CTRL, 32'h7);
      idle(17);
      chk_reg("R8 carry compare low", A_CMP_LO, 32'h10);
      chk_reg("R8 carry compare high", A_CMP_HI, 32'd3);
      wr(A_CTRL, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      idle(2);
      t_latency;
      t_ack_clear;
      t_counter;
      t_match;
      t_disabled;
      t_auto;
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule